// File: doc/BRIEF.md
# Early-Reset Dual-Rail Ripple Adder with Synchronized Carry-Out

This block adds two W-bit operands and a carry-in. Every operand bit, the carry-in, every sum bit and the carry-out uses two rails. A high true rail means 1, a high false rail means 0, and both rails low is the spacer. Operands alternate between a full codeword and an all-spacer word. The adder is a chain of full-adder cells. Each cell builds its carry from input-incomplete AND-OR terms, so an operand rail that returns to zero clears the carry without waiting for the carry-in. Each sum rail comes from state-holding C-elements, so a sum bit still reports the arrival and the withdrawal of every input of its cell.

Because the cells release early, the stage as a whole does not confirm its inputs. The top restores that confirmation at stage level. Its only means is the final carry-out. Each rail of that carry passes through a 2-input C-element whose second input is the stage completion signal, `ackout`, which comes from outside. The sum rails go straight out. The C-elements are modelled as clocked hold elements: one cycle after their inputs agree, each one takes their common value. A synchronous active-high reset clears every element to spacer.

Top module: `dr_eo_adder`

## Requirements
- R1: While `rst` is high at a clock edge, all sum rails and both carry-out rails are 0 (spacer) after that edge.
- R2: One clock after a full codeword is applied, bit i of the binary value a+b+cin appears on the sum rails. `sum_t[i]` is high for a 1 and `sum_f[i]` is high for a 0.
- R3: The sums resolve whatever the state of `ackout`. They are valid one clock after the codeword even while `ackout` is low.
- R4: While `ackout` is low, the carry-out rails do not leave spacer, even though the inputs are valid.
- R5: One clock after `ackout` rises with valid inputs, the carry-out shows bit W of a+b+cin. `cout_t` is high for 1 and `cout_f` is high for 0.
- R6: While `ackout` stays high, the carry-out keeps its valid value after the inputs return to spacer.
- R7: One clock after `ackout` falls with the inputs at spacer, both carry-out rails are 0.
- R8: One clock after every input is at spacer, all sum rails are 0.
- R9: Early reset. If both operands return to spacer while the carry-in stays valid, then one clock later sum bits 1 to W-1 are spacer and bit 0 keeps its value.
- R10: No sum bit and no carry-out ever has both rails high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the modelled C-element state |
| rst | input | 1 | Synchronous active-high reset to spacer |
| a_t | input | W | Operand A true rails |
| a_f | input | W | Operand A false rails |
| b_t | input | W | Operand B true rails |
| b_f | input | W | Operand B false rails |
| cin_t | input | 1 | Carry-in true rail |
| cin_f | input | 1 | Carry-in false rail |
| ackout | input | 1 | Stage completion signal joined with the carry-out |
| sum_t | output | W | Sum true rails |
| sum_f | output | W | Sum false rails |
| cout_t | output | 1 | Synchronized carry-out true rail |
| cout_f | output | 1 | Synchronized carry-out false rail |

## Verification
The bench holds `ackout` low after each codeword and checks that the sums have resolved while the carry-out is still spacer. A design that fed the carry straight out would fail here, and so would one that gated the sums as well. It then checks that the carry stays valid across the spacer phase until `ackout` drops. A synchronizer built from plain AND gates instead of C-elements would clear it too early. The vectors include a carry that ripples through every bit. A directed test withdraws only the operands and checks that the upper sum bits clear while bit 0, still held by a valid carry-in, does not. A cell whose carry waited for its carry-in, or whose sum released early, would show up there.

// File: rtl/dr_eo_pkg.sv
package dr_eo_pkg;
  typedef struct packed {
    logic t;
    logic f;
  } dr_bit_t;

  localparam dr_bit_t DR_SPACER = '{t: 1'b0, f: 1'b0};
endpackage

// File: rtl/dr_celem.sv
module dr_celem (
  input  logic clk,
  input  logic rst,
  input  logic x,
  input  logic y,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (x == y)
      q <= x;
  end
endmodule

// File: rtl/dr_eo_cell.sv
module dr_eo_cell
  import dr_eo_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  dr_bit_t a,
  input  dr_bit_t b,
  input  dr_bit_t ci,
  output dr_bit_t s,
  output dr_bit_t co
);
  logic same_ops, diff_ops;
  logic c_same_t, c_same_f, c_diff_t, c_diff_f;

  // input-incomplete AND-OR terms
  assign same_ops = (a.f & b.f) | (a.t & b.t);
  assign diff_ops = (a.f & b.t) | (a.t & b.f);
  assign co.t     = (diff_ops & ci.t) | (a.t & b.t);
  assign co.f     = (diff_ops & ci.f) | (a.f & b.f);

  // sum rails are built from state-holding C-elements
  dr_celem u_same_t (.clk(clk), .rst(rst), .x(same_ops), .y(ci.t), .q(c_same_t));
  dr_celem u_same_f (.clk(clk), .rst(rst), .x(same_ops), .y(ci.f), .q(c_same_f));
  dr_celem u_diff_t (.clk(clk), .rst(rst), .x(diff_ops), .y(ci.f), .q(c_diff_t));
  dr_celem u_diff_f (.clk(clk), .rst(rst), .x(diff_ops), .y(ci.t), .q(c_diff_f));

  assign s.t = c_same_t | c_diff_t;
  assign s.f = c_same_f | c_diff_f;
endmodule

// File: rtl/dr_eo_adder.sv
module dr_eo_adder
  import dr_eo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  input  logic         cin_t,
  input  logic         cin_f,
  input  logic         ackout,
  output logic [W-1:0] sum_t,
  output logic [W-1:0] sum_f,
  output logic         cout_t,
  output logic         cout_f
);
  localparam int NCARRY = W + 1;

  dr_bit_t chain [NCARRY];

  assign chain[0] = '{t: cin_t, f: cin_f};

  for (genvar i = 0; i < W; i++) begin : g_bit
    dr_bit_t s_i;
    dr_eo_cell u_cell (
      .clk (clk),
      .rst (rst),
      .a   ('{t: a_t[i], f: a_f[i]}),
      .b   ('{t: b_t[i], f: b_f[i]}),
      .ci  (chain[i]),
      .s   (s_i),
      .co  (chain[i+1])
    );
    assign sum_t[i] = s_i.t;
    assign sum_f[i] = s_i.f;
  end

  // stage-level indication: final carry meets the completion signal
  dr_celem u_sync_t (.clk(clk), .rst(rst), .x(chain[W].t), .y(ackout), .q(cout_t));
  dr_celem u_sync_f (.clk(clk), .rst(rst), .x(chain[W].f), .y(ackout), .q(cout_f));
endmodule

// File: rtl/dr_eo_adder_checker.sv
module dr_eo_adder_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ackout,
  input logic [W-1:0] sum_t,
  input logic [W-1:0] sum_f,
  input logic         cout_t,
  input logic         cout_f
);
  // R1
  p_reset_spacer_r1: assert property (@(posedge clk)
    rst |=> (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f));

  // R4: the carry may only leave spacer when ackout was high
  p_cout_t_wait_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cout_t) |-> $past(ackout));
  p_cout_f_wait_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cout_f) |-> $past(ackout));

  // R7: the carry may only return to spacer when ackout was low
  p_cout_t_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cout_t) |-> !$past(ackout));
  p_cout_f_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cout_f) |-> !$past(ackout));

  // R10
  p_cout_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cout_t, cout_f}));
  p_sum_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    (sum_t & sum_f) == '0);
endmodule

bind dr_eo_adder dr_eo_adder_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ackout (ackout),
  .sum_t  (sum_t),
  .sum_f  (sum_f),
  .cout_t (cout_t),
  .cout_f (cout_f)
);

// File: tb/dr_eo_adder_bench.sv
module dr_eo_adder_bench;
  localparam int W = 8;
  localparam int NV = 8;
  // {a, b, cin}
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0},
    {8'hFF, 8'h01, 1'b0},
    {8'hFF, 8'hFF, 1'b1},
    {8'hAA, 8'h55, 1'b1},
    {8'h80, 8'h80, 1'b0},
    {8'h12, 8'h34, 1'b1},
    {8'h7F, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic cin_t = 1'b0, cin_f = 1'b0, ackout = 1'b0;
  logic [W-1:0] sum_t, sum_f;
  logic cout_t, cout_f;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dr_eo_adder #(.W(W)) u_dr_eo_adder (
    .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f), .ackout(ackout),
    .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_valid(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
  endtask

  task automatic drive_spacer();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step();
    step();
    rst = 1'b0;
    // R1: outputs at spacer after reset
    chk("R1", {sum_t, sum_f, 14'd0, cout_t, cout_f}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] va, vb;
      logic vc;
      logic [W:0] tot;
      va = VEC[v][16:9];
      vb = VEC[v][8:1];
      vc = VEC[v][0];
      tot = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
      ackout = 1'b0;
      drive_valid(va, vb, vc);
      step();
      // R2, R3: sums resolved with ackout still low
      chk("R2/R3 sum", {sum_t, sum_f}, {tot[W-1:0], ~tot[W-1:0]});
      // R4: carry held at spacer
      chk("R4", {cout_t, cout_f}, 32'd0);
      ackout = 1'b1;
      step();
      chk("R5", {cout_t, cout_f}, {tot[W], ~tot[W]});
      drive_spacer();
      step();
      chk("R8", {sum_t, sum_f}, 32'd0);
      chk("R6", {cout_t, cout_f}, {tot[W], ~tot[W]});
      ackout = 1'b0;
      step();
      chk("R7", {cout_t, cout_f}, 32'd0);
    end

    // R9: early reset, operands withdrawn while carry-in stays valid
    drive_valid(8'h05, 8'h03, 1'b1);
    step();
    chk("R9 setup", {sum_t, sum_f}, {8'h09, 8'hF6});
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    step();
    chk("R9", {sum_t, sum_f}, {8'h01, 8'h00});
    chk("R9 cout", {cout_t, cout_f}, 32'd0);
    cin_t = 1'b0; cin_f = 1'b0;
    step();
    chk("R8 after R9", {sum_t, sum_f}, 32'd0);

    // R4 and R7 with a carry of 1 while ackout toggles late
    drive_valid(8'hF0, 8'h10, 1'b0);
    step();
    step();
    chk("R4 hold", {cout_t, cout_f}, 32'd0);
    ackout = 1'b1;
    step();
    chk("R5 late ack", {cout_t, cout_f}, 32'd2);
    drive_spacer();
    step();
    step();
    chk("R6 long", {cout_t, cout_f}, 32'd2);
    ackout = 1'b0;
    step();
    chk("R7 late", {cout_t, cout_f}, 32'd0);

    // R1: reset in the middle of a valid word
    drive_valid(8'h33, 8'h44, 1'b1);
    ackout = 1'b1;
    step();
    step();
    rst = 1'b1;
    step();
    chk("R1 mid", {sum_t, sum_f, 14'd0, cout_t, cout_f}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule